// File: doc/BRIEF.md
# Pseudo-Random Memory Test Sequencer

This block tests a memory reached through a simple request/acknowledge port. Such a port hides refresh, bank and row activation and address multiplexing behind it. A pulse on `start` launches two passes over a fixed address window. The first pass stores a pseudo-random word at every address. The second pass reloads the generator with the same seed and reads the window back. Each returned word is compared with the regenerated value for that address.

The reference data is never stored. A single Fibonacci shift register produces it for writing and produces it again for checking. The register steps only when a memory transaction completes, so memory latency of any length cannot shift the sequence against the addresses.

When the run ends, `done` rises together with exactly one of `pass` or `fail`. On a failure, the address that first failed is held on `fail_addr`.

Top module: `mem_lfsr_tester`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `pass` and `fail` are 0, and neither `mem_rd` nor `mem_wr` is asserted until `start` is seen.
- R2: After `start`, the block writes each address from `FIRST` up to `LAST` in ascending order. The first word written is `SEED`. Each following word is the generator's next state, `{s[DW-2:0], ^(s & TAPS)}`. The default `TAPS` is 16'hB400, a maximal-length tap set for 16 bits.
- R3: At most one of `mem_rd` and `mem_wr` is high at a time. A raised strobe stays high, with `mem_addr` and `mem_wdata` unchanged, until `mem_ack` is seen.
- R4: The generator and the address advance once per acknowledged transaction. Wait cycles of any length do not change the word sent to or expected from any address.
- R5: After the ack for `LAST` in the write pass, the block reads addresses `FIRST` to `LAST` in ascending order. Each word read is compared with the sequence regenerated from `SEED`.
- R6: If every address matches, `pass` and `done` become 1, `fail` stays 0, and no further memory requests are issued.
- R7: At the first read word that differs from its expected value, `fail` and `done` become 1 and `fail_addr` takes that address. No further requests are issued.
- R8: `start` is ignored while a pass is running. When the block is idle or finished, `start` clears `done`, `pass` and `fail` and begins a new run from `FIRST` and `SEED`.
- R9: `done`, `pass`, `fail` and `fail_addr` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (honoured only when idle or finished) |
| mem_rd | output | 1 | Read request strobe, held until ack |
| mem_wr | output | 1 | Write request strobe, held until ack |
| mem_addr | output | AW | Memory address of the pending request |
| mem_wdata | output | DW | Write data of the pending request |
| mem_rdata | input | DW | Read data, valid in the ack cycle |
| mem_ack | input | 1 | One-cycle transaction completion |
| done | output | 1 | Run finished |
| pass | output | 1 | Whole window matched |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | AW | Address of the first mismatch |

## Verification
Two situations are hard to reach from the ports. One is a mismatch at the window's edges, the first and last address. The other is a `start` pulse arriving in the middle of a long wait for an ack. The memory model corrupts one chosen address on read and stretches each ack by a latency that depends on the address. The stimulus places the fault at `FIRST`, in the middle of the window and at `LAST`, and pulses `start` while a request is pending. The scoreboard confirms that the transaction stream and its data are unaffected by that pulse.

// File: rtl/mem_lfsr_tester.sv
module mem_lfsr_tester #(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int FIRST = 0,
  parameter int LAST  = 1023,
  parameter int SEED  = 'hACE1,
  parameter int TAPS  = 'hB400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam logic [AW-1:0] A_FIRST = AW'(FIRST);
  localparam logic [AW-1:0] A_LAST  = AW'(LAST);
  localparam logic [DW-1:0] SEED_V  = DW'(SEED);
  localparam logic [DW-1:0] TAPS_V  = DW'(TAPS);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_VERIFY, S_HALT} state_t;

  state_t        st;
  logic [AW-1:0] addr;
  logic [DW-1:0] lfsr;

  wire [DW-1:0] lfsr_nxt = {lfsr[DW-2:0], ^(lfsr & TAPS_V)};
  wire          at_last  = (addr == A_LAST);
  wire          can_go   = (st == S_IDLE) || (st == S_HALT);

  assign mem_wr    = (st == S_WRITE);
  assign mem_rd    = (st == S_VERIFY);
  assign mem_addr  = addr;
  assign mem_wdata = lfsr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= A_FIRST;
      lfsr      <= SEED_V;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (can_go && start) begin
      st        <= S_WRITE;
      addr      <= A_FIRST;
      lfsr      <= SEED_V;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      case (st)
        S_WRITE: if (mem_ack) begin
          if (at_last) begin
            st   <= S_VERIFY;
            addr <= A_FIRST;
            lfsr <= SEED_V;
          end else begin
            addr <= addr + 1'b1;
            lfsr <= lfsr_nxt;
          end
        end
        S_VERIFY: if (mem_ack) begin
          if (mem_rdata != lfsr) begin
            st        <= S_HALT;
            fail      <= 1'b1;
            done      <= 1'b1;
            fail_addr <= addr;
          end else if (at_last) begin
            st   <= S_HALT;
            pass <= 1'b1;
            done <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
            lfsr <= lfsr_nxt;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module mem_lfsr_tester_chk #(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter int LAST = 1023
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [AW-1:0] fail_addr
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=>
      ($stable(mem_rd) && $stable(mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr <= AW'(LAST)));

  a_r6_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_rd || mem_wr));

  a_r9_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail) && $stable(fail_addr)));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack && start) |=> (mem_rd || mem_wr));
endmodule

bind mem_lfsr_tester mem_lfsr_tester_chk #(.AW(AW), .DW(DW), .LAST(LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .done(done),
  .pass(pass), .fail(fail), .fail_addr(fail_addr)
);

// File: tb/mem_lfsr_tester_test.sv
`timescale 1ns/1ps
module mem_lfsr_tester_test;
  localparam int AW = 6, DW = 16, FIRST = 3, LAST = 20;
  localparam logic [DW-1:0] SEED = 16'hACE1, TAPS = 16'hB400;

  logic clk = 0, rst_n = 0, start = 0;
  logic mem_rd, mem_wr, mem_ack = 0, done, pass, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  mem_lfsr_tester #(.AW(AW), .DW(DW), .FIRST(FIRST), .LAST(LAST),
                    .SEED(int'(SEED)), .TAPS(int'(TAPS))) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural memory with variable latency and a read fault
  logic [DW-1:0] ram [0:63];
  int  cnt = 0, lat_mode = 0;
  bit  fault_on = 0;
  logic [AW-1:0] fault_a = '0;
  function automatic int lat_of(input logic [AW-1:0] a);
    return (lat_mode == 0) ? 0 : int'(a % 4) + 1;
  endfunction
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (!rst_n) cnt <= 0;
    else if ((mem_rd || mem_wr) && !mem_ack) begin
      if (cnt >= lat_of(mem_addr)) begin
        mem_ack <= 1'b1;
        cnt <= 0;
        if (mem_wr) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr] ^ ((fault_on && mem_addr == fault_a) ? 16'h0004 : 16'h0000);
      end else cnt <= cnt + 1;
    end
  end

  // scoreboard: {is_write, addr, data}
  logic [AW+DW:0] expq[$];

  always @(negedge clk) begin
    if (rst_n && mem_ack) begin
      chk(mem_rd ^ mem_wr, "R3", "exactly one strobe at ack", {mem_rd, mem_wr}, 1);
      if (expq.size() == 0) begin
        chk(0, "R7", "transaction beyond expected stream", mem_addr, 0);
      end else begin
        logic [AW+DW:0] e;
        e = expq.pop_front();
        chk(mem_wr == e[AW+DW], e[AW+DW] ? "R2" : "R5", "transaction kind", mem_wr, e[AW+DW]);
        chk(mem_addr == e[AW+DW-1:DW], e[AW+DW] ? "R2" : "R5", "address", mem_addr, e[AW+DW-1:DW]);
        if (e[AW+DW])
          chk(mem_wdata == e[DW-1:0], "R4", "write word", mem_wdata, e[DW-1:0]);
      end
    end
  end

  function automatic logic [DW-1:0] step(input logic [DW-1:0] s);
    return {s[DW-2:0], ^(s & TAPS)};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run(input bit f_on, input int fa, input int lm, input bit mid_start);
    logic [DW-1:0] s;
    int n;
    fault_on = f_on; fault_a = AW'(fa); lat_mode = lm;
    s = SEED;
    for (int a = FIRST; a <= LAST; a++) begin expq.push_back({1'b1, AW'(a), s}); s = step(s); end
    s = SEED;
    for (int a = FIRST; a <= LAST; a++) begin
      expq.push_back({1'b0, AW'(a), s}); s = step(s);
      if (f_on && a == fa) break;
    end
    pulse_start();
    chk(!done && !pass && !fail, "R8", "flags cleared by start", {done, pass, fail}, 0);
    if (mid_start) begin
      repeat (7) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R6", "run completes", done, 1);
    if (f_on) begin
      chk(fail && !pass, "R7", "fail verdict", {pass, fail}, 1);
      chk(fail_addr == AW'(fa), "R7", "first failing address", fail_addr, fa);
    end else begin
      chk(pass && !fail, "R6", "pass verdict", {pass, fail}, 2);
    end
    repeat (12) @(negedge clk);
    chk(!mem_rd && !mem_wr, "R7", "no requests after verdict", {mem_rd, mem_wr}, 0);
    chk(expq.size() == 0, "R5", "expected stream consumed", expq.size(), 0);
    chk(done && (pass == !f_on) && (fail == f_on), "R9", "verdict held", {done, pass, fail}, {1'b1, !f_on, f_on});
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !pass && !fail, "R1", "flags in reset", {done, pass, fail}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!mem_rd && !mem_wr && !done, "R1", "idle after reset", {mem_rd, mem_wr, done}, 0);
    run(0, 0, 0, 0);
    run(1, 11, 1, 1);
    run(1, FIRST, 0, 0);
    run(1, LAST, 1, 1);
    run(0, 0, 1, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule